// File: doc/BRIEF.md
# Adaptive Diagnostic Tree Sequencer

The block steers an adaptive fault-location experiment. A diagnostic tree sits in a small node memory outside the block. Each word of that memory is either a decision node or a leaf. A decision node names one test pattern and holds two child pointers, one taken when the pattern passes and one taken when it fails. A leaf carries a bitmap of the suspect faults. A leaf may name a single fault, or a group of faults that the patterns applied on the way there cannot tell apart.

A walk begins at address 0, which stands for the whole modeled fault population. At each decision node the sequencer requests one pattern from an external tester. It holds the request until the tester returns a verdict, then fetches the child that matches the verdict. The next pattern therefore depends on the last result, and paths through the tree differ in length. When a leaf is reached, the block presents the leaf's fault set and the number of patterns it applied. A null child pointer, or a walk longer than the node count, ends the walk with an error flag.

Top module: `diag_tree_walker`

## Requirements
- R1: After reset, busy_o, done_o, err_o, req_o and node_rd_o are 0, and pat_cnt_o and fault_set_o are 0.
- R2: A start_i pulse accepted while not busy begins a walk by reading node address 0. Read data is expected on node_data_i one cycle after node_rd_o is high. Bit 16 of a node word is the leaf flag, where 1 means leaf.
- R3: At a decision node, req_o is raised with pat_idx_o equal to word bits [13:10]. req_o and pat_idx_o stay unchanged until valid_i is seen high.
- R4: On an accepted verdict with fail_i=1, the next node is read from the address in word bits [4:0]. With fail_i=0, the address comes from bits [9:5].
- R5: On reaching a leaf, done_o goes high and fault_set_o equals word bits [15:0]. Both hold until the next accepted start.
- R6: pat_cnt_o equals the number of verdicts accepted since the current walk started. A root leaf gives 0.
- R7: A selected child pointer of 0 ends the walk with err_o high and fault_set_o at 0. The verdict that selected it is counted.
- R8: If a decision node is fetched after NODES verdicts have already been accepted in the walk, the walk ends with err_o high and pat_cnt_o equal to NODES.
- R9: start_i is ignored while busy. valid_i is ignored while req_o is low.
- R10: A start after done or error clears the previous result and walks the tree again from the root.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a walk at the root |
| node_rd_o | output | 1 | Node memory read strobe |
| node_addr_o | output | 5 | Node memory address |
| node_data_i | input | 17 | Node word, one cycle after the read strobe |
| req_o | output | 1 | Pattern request to the tester |
| pat_idx_o | output | 4 | Index of the requested pattern |
| valid_i | input | 1 | Tester verdict valid |
| fail_i | input | 1 | Verdict: 1 = fail, 0 = pass |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Leaf reached |
| err_o | output | 1 | Walk aborted on a malformed tree |
| fault_set_o | output | 16 | Fault bitmap of the leaf reached |
| pat_cnt_o | output | 6 | Patterns applied in this walk |

## Verification
A wrong next-node choice shows at the ports on the very next request, as an unexpected pat_idx_o. If that node is a leaf, it shows instead as a wrong fault_set_o or a premature done_o. A counter that drifts shows in pat_cnt_o at the end of the walk, and its effect on the depth guard shows as an error at the wrong step. Request-hold faults show within one cycle of a delayed verdict. Stale results after a restart show in the first cycles of the new walk.

// File: rtl/diag_tree_pkg.sv
package diag_tree_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_EVAL,
    S_REQ,
    S_DONE,
    S_ERR
  } walk_state_e;
endpackage

// File: rtl/diag_node_decode.sv
module diag_node_decode #(
  parameter int PTR_W  = 5,
  parameter int PAT_W  = 4,
  parameter int FSET_W = 16,
  localparam int TST_W = PAT_W + 2 * PTR_W,
  localparam int BODY_W = (FSET_W > TST_W) ? FSET_W : TST_W,
  localparam int WORD_W = BODY_W + 1
) (
  input  logic [WORD_W-1:0] word_i,
  output logic              is_leaf_o,
  output logic [PAT_W-1:0]  pat_o,
  output logic [PTR_W-1:0]  pass_ptr_o,
  output logic [PTR_W-1:0]  fail_ptr_o,
  output logic [FSET_W-1:0] fset_o
);
  always_comb begin
    is_leaf_o  = word_i[WORD_W-1];
    fail_ptr_o = word_i[PTR_W-1:0];
    pass_ptr_o = word_i[2*PTR_W-1:PTR_W];
    pat_o      = word_i[TST_W-1:2*PTR_W];
    fset_o     = word_i[FSET_W-1:0];
  end
endmodule

// File: rtl/diag_step_cnt.sv
module diag_step_cnt #(
  parameter int NODES = 32,
  localparam int CNT_W = $clog2(NODES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             at_max_o
);
  localparam logic [CNT_W-1:0] MAX = CNT_W'(NODES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_o <= '0;
    else if (clr_i)             cnt_o <= '0;
    else if (inc_i && !at_max_o) cnt_o <= cnt_o + 1'b1;
  end

  assign at_max_o = (cnt_o == MAX);

  a_r8_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= MAX);
  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0);
endmodule

// File: rtl/diag_walk_ctrl.sv
module diag_walk_ctrl
  import diag_tree_pkg::*;
#(
  parameter int NODES  = 32,
  parameter int PAT_W  = 4,
  parameter int FSET_W = 16,
  localparam int PTR_W = $clog2(NODES),
  localparam int CNT_W = $clog2(NODES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              valid_i,
  input  logic              fail_i,
  input  logic              is_leaf_i,
  input  logic [PAT_W-1:0]  pat_i,
  input  logic [PTR_W-1:0]  pass_ptr_i,
  input  logic [PTR_W-1:0]  fail_ptr_i,
  input  logic [FSET_W-1:0] fset_i,
  input  logic              at_max_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              node_rd_o,
  output logic [PTR_W-1:0]  node_addr_o,
  output logic              req_o,
  output logic [PAT_W-1:0]  pat_idx_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [FSET_W-1:0] fault_set_o,
  output logic              cnt_clr_o,
  output logic              cnt_inc_o
);
  walk_state_e state_q;
  logic [PTR_W-1:0]  addr_q, pass_q, fail_q, next_ptr;
  logic [PAT_W-1:0]  pat_q;
  logic [FSET_W-1:0] fset_q;

  always_comb begin
    node_rd_o   = (state_q == S_FETCH);
    req_o       = (state_q == S_REQ);
    busy_o      = (state_q == S_FETCH) || (state_q == S_EVAL) || (state_q == S_REQ);
    done_o      = (state_q == S_DONE);
    err_o       = (state_q == S_ERR);
    node_addr_o = addr_q;
    pat_idx_o   = pat_q;
    fault_set_o = fset_q;
    cnt_clr_o   = start_i && !busy_o;
    cnt_inc_o   = req_o && valid_i;
    next_ptr    = fail_i ? fail_q : pass_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      pass_q  <= '0;
      fail_q  <= '0;
      pat_q   <= '0;
      fset_q  <= '0;
    end else begin
      case (state_q)
        S_FETCH: state_q <= S_EVAL;
        S_EVAL: begin
          if (is_leaf_i) begin
            fset_q  <= fset_i;
            state_q <= S_DONE;
          end else if (at_max_i) begin
            state_q <= S_ERR;
          end else begin
            pat_q   <= pat_i;
            pass_q  <= pass_ptr_i;
            fail_q  <= fail_ptr_i;
            state_q <= S_REQ;
          end
        end
        S_REQ: begin
          if (valid_i) begin
            if (next_ptr == '0) begin
              state_q <= S_ERR;
            end else begin
              addr_q  <= next_ptr;
              state_q <= S_FETCH;
            end
          end
        end
        default: begin
          if (start_i) begin
            addr_q  <= '0;
            fset_q  <= '0;
            state_q <= S_FETCH;
          end
        end
      endcase
    end
  end

  // R3: request and pattern held until verdict
  a_r3_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !valid_i) |=> (req_o && $stable(pat_idx_o)));
  a_r5_done_err_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o) && !(busy_o && (done_o || err_o)));
  a_r5_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(fault_set_o)));
  a_r7_err_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (fault_set_o == '0));
  a_r6_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && valid_i && !at_max_i) |=> (cnt_i == $past(cnt_i) + 1'b1));
  a_r9_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !cnt_inc_o) |=> $stable(cnt_i));
endmodule

// File: rtl/diag_tree_walker.sv
module diag_tree_walker #(
  parameter int NODES  = 32,
  parameter int PAT_W  = 4,
  parameter int FSET_W = 16,
  localparam int PTR_W = $clog2(NODES),
  localparam int CNT_W = $clog2(NODES + 1),
  localparam int TST_W = PAT_W + 2 * PTR_W,
  localparam int WORD_W = ((FSET_W > TST_W) ? FSET_W : TST_W) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              node_rd_o,
  output logic [PTR_W-1:0]  node_addr_o,
  input  logic [WORD_W-1:0] node_data_i,
  output logic              req_o,
  output logic [PAT_W-1:0]  pat_idx_o,
  input  logic              valid_i,
  input  logic              fail_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [FSET_W-1:0] fault_set_o,
  output logic [CNT_W-1:0]  pat_cnt_o
);
  logic              is_leaf, at_max, cnt_clr, cnt_inc;
  logic [PAT_W-1:0]  dec_pat;
  logic [PTR_W-1:0]  dec_pass, dec_fail;
  logic [FSET_W-1:0] dec_fset;

  diag_node_decode #(.PTR_W(PTR_W), .PAT_W(PAT_W), .FSET_W(FSET_W)) i_decode (
    .word_i     (node_data_i),
    .is_leaf_o  (is_leaf),
    .pat_o      (dec_pat),
    .pass_ptr_o (dec_pass),
    .fail_ptr_o (dec_fail),
    .fset_o     (dec_fset)
  );

  diag_step_cnt #(.NODES(NODES)) i_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (cnt_clr),
    .inc_i    (cnt_inc),
    .cnt_o    (pat_cnt_o),
    .at_max_o (at_max)
  );

  diag_walk_ctrl #(.NODES(NODES), .PAT_W(PAT_W), .FSET_W(FSET_W)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .valid_i     (valid_i),
    .fail_i      (fail_i),
    .is_leaf_i   (is_leaf),
    .pat_i       (dec_pat),
    .pass_ptr_i  (dec_pass),
    .fail_ptr_i  (dec_fail),
    .fset_i      (dec_fset),
    .at_max_i    (at_max),
    .cnt_i       (pat_cnt_o),
    .node_rd_o   (node_rd_o),
    .node_addr_o (node_addr_o),
    .req_o       (req_o),
    .pat_idx_o   (pat_idx_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .fault_set_o (fault_set_o),
    .cnt_clr_o   (cnt_clr),
    .cnt_inc_o   (cnt_inc)
  );

  a_r2_root_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (node_rd_o && node_addr_o == '0));
endmodule

// File: tb/test_diag_tree_walker.sv
module test_diag_tree_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, valid = 1'b0, fail = 1'b0;
  logic        node_rd, req, busy, done, err;
  logic [4:0]  node_addr;
  logic [16:0] rdata = '0;
  logic [3:0]  pat_idx;
  logic [15:0] fset;
  logic [5:0]  cnt;
  logic [16:0] mem [32];
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  diag_tree_walker i_diag_tree_walker (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .node_rd_o(node_rd), .node_addr_o(node_addr), .node_data_i(rdata),
    .req_o(req), .pat_idx_o(pat_idx), .valid_i(valid), .fail_i(fail),
    .busy_o(busy), .done_o(done), .err_o(err),
    .fault_set_o(fset), .pat_cnt_o(cnt)
  );

  always_ff @(posedge clk) if (node_rd) rdata <= mem[node_addr];

  function automatic logic [16:0] tnode(int p, int pp, int fp);
    return {1'b0, 2'b00, 4'(p), 5'(pp), 5'(fp)};
  endfunction
  function automatic logic [16:0] lnode(logic [15:0] bm);
    return {1'b1, bm};
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // fails: bit i = verdict for step i; pats: nibble i = expected pattern at step i
  task automatic walk(string tag, logic [63:0] fails, logic [63:0] pats, bit chk_pat,
                      int exp_n, bit exp_err, logic [15:0] exp_fs);
    int step = 0;
    pulse_start();
    for (int g = 0; g < 400; g++) begin
      if (done || err) break;
      if (req) begin
        if (chk_pat) check(pat_idx == pats[4*step +: 4], {tag, " R3 pattern"}, 32'(pat_idx), 32'(pats[4*step +: 4]));
        valid = 1'b1; fail = fails[step];
        @(negedge clk); valid = 1'b0; fail = 1'b0;
        step++;
      end else @(negedge clk);
    end
    check(err == exp_err && done == !exp_err, {tag, " R5/R7 end flag"}, {err, done}, {exp_err, !exp_err});
    check(fset == exp_fs, {tag, " R5 fault set"}, 32'(fset), 32'(exp_fs));
    check(cnt == 6'(exp_n), {tag, " R6 count"}, 32'(cnt), 32'(exp_n));
  endtask

  task automatic load_main();
    for (int i = 0; i < 32; i++) mem[i] = lnode(16'h0);
    mem[0]  = tnode(3, 1, 2);
    mem[1]  = tnode(5, 3, 4);
    mem[2]  = tnode(1, 5, 6);
    mem[3]  = tnode(7, 7, 8);
    mem[4]  = lnode(16'h0040);
    mem[5]  = lnode(16'h0004);
    mem[6]  = lnode(16'h0088);
    mem[7]  = lnode(16'h0000);
    mem[8]  = tnode(2, 9, 10);
    mem[9]  = lnode(16'h0002);
    mem[10] = lnode(16'h0030);
  endtask

  task automatic t_reset();
    check(!busy && !done && !err && !req && !node_rd, "R1 flags", {busy, done, err, req, node_rd}, 0);
    check(cnt == 0 && fset == 0, "R1 outputs", {cnt, fset}, 0);
  endtask

  task automatic t_paths();
    load_main();
    walk("R4 fail-fail", 64'b11, 64'h13, 1, 2, 0, 16'h0088);
    walk("R4 pass-fail", 64'b10, 64'h53, 1, 2, 0, 16'h0040);
    walk("R2 pass-pass-fail-fail", 64'b1100, 64'h2753, 1, 4, 0, 16'h0030);
    walk("R2 pass-pass-fail-pass", 64'b0100, 64'h2753, 1, 4, 0, 16'h0002);
    walk("R10 pass-pass-pass", 64'b000, 64'h753, 1, 3, 0, 16'h0000);
  endtask

  task automatic t_hold_and_ignore();
    logic [5:0]  c0;
    logic [15:0] f0;
    load_main();
    pulse_start();
    while (!req) @(negedge clk);
    start = 1'b1; // R9 start while busy
    repeat (3) @(negedge clk);
    start = 1'b0;
    check(req && pat_idx == 4'd3, "R3 hold", {req, pat_idx}, {1'b1, 4'd3});
    check(cnt == 0, "R9 start busy count", 32'(cnt), 0);
    valid = 1'b1; fail = 1'b1; @(negedge clk); valid = 1'b0;
    while (!req) @(negedge clk);
    check(pat_idx == 4'd1, "R4 fail branch", 32'(pat_idx), 1);
    valid = 1'b1; fail = 1'b0; @(negedge clk); valid = 1'b0; fail = 1'b0;
    while (!done && !err) @(negedge clk);
    check(done && fset == 16'h0004 && cnt == 2, "R9 unaffected result", {fset, cnt}, {16'h0004, 6'd2});
    c0 = cnt; f0 = fset;
    valid = 1'b1; fail = 1'b1;
    repeat (4) @(negedge clk);
    valid = 1'b0; fail = 1'b0;
    check(done && cnt == c0 && fset == f0 && !req, "R9 stray verdict", {cnt, fset}, {c0, f0});
  endtask

  task automatic t_errors();
    for (int i = 0; i < 32; i++) mem[i] = lnode(16'h0);
    mem[0] = lnode(16'hA5C3);
    walk("R6 root leaf", 64'b0, 64'h0, 0, 0, 0, 16'hA5C3);
    mem[0] = tnode(9, 0, 2);
    mem[2] = lnode(16'h1111);
    walk("R7 null pass", 64'b0, 64'h9, 1, 1, 1, 16'h0000);
    walk("R10 after error", 64'b1, 64'h9, 1, 1, 0, 16'h1111);
    mem[0] = tnode(4, 1, 1);
    mem[1] = tnode(4, 1, 1);
    walk("R8 depth", 64'b0, 64'h0, 0, 32, 1, 16'h0000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 32; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_paths();
    t_hold_and_ignore();
    t_errors();
    finish_run();
  end
endmodule